// File: doc/BRIEF.md
# Register Rename and Station Issue Stage

This block sits between an in-order operation queue and the reservation stations of an out-of-order execution core. Each accepted instruction is given a free station of the unit class it asks for (adder, multiplier, load buffer, store buffer). For each of its two source registers, the block hands the station either the register's committed value or the tag of the station that will produce it. If the instruction has a destination, that register is renamed to the new station's tag. This removes write-after-read and write-after-write stalls.

The block also watches the result broadcast bus. A broadcast frees the station that sent it. It writes the register file only where a register's status still names that station, and it clears that status. A result from an older producer whose register has since been renamed goes only to waiting consumers and is never committed. Same-cycle interactions between issue and broadcast are resolved inside the block: a source whose producer broadcasts now takes the broadcast value, and a destination renamed now keeps its new tag.

The queue side is valid/ready. An instruction transfers on a cycle where `iq_valid` and `iq_ready` are both high. `iq_ready` depends on the class presented in the same cycle, so the queue holds the head instruction, and everything behind it, until a station of that class frees up. The allocation side has no back-pressure: `al_valid` marks the transfer cycle, and the chosen station must latch the payload on that edge. The broadcast bus is accepted every cycle.

Top module: `rn_issue_stage`

## Requirements
- R1: After reset every register holds value 0 with blank status (tag 0), and every station is free.
- R2: Station tags are global station index plus one. Class 0 (adder) owns tags 1-3, class 1 (multiplier) tags 4-5, class 2 (load) tags 6-11 and class 3 (store) tags 12-14. An accepted instruction gets the lowest-numbered free tag of its class, and that station is busy from the next cycle.
- R3: `iq_ready` is high only when the presented class has a free station. With no free station, nothing is allocated and no status changes.
- R4: At issue, a source with blank status is sent as its register value with tag 0. A source with pending status is sent as the producer tag with value 0.
- R5: When `iq_dst_en` is set, an accepted instruction overwrites its destination status with its new tag, even if an earlier writer is still pending. Its own sources read the status from before this rename.
- R6: A broadcast writes a register, and clears its status to 0 in the same edge, only if that register's status equals the broadcast tag. A result from a producer whose register was renamed later is not written.
- R7: A broadcast on `bc_tag` frees that station from the next cycle, so it can be allocated again.
- R8: A source whose pending producer broadcasts in the issue cycle is sent the broadcast data with tag 0.
- R9: If the issuing instruction renames a register that a broadcast writes in the same cycle, the register takes the data and its status takes the new tag.
- R10: All six load buffers can be held at once by loads with different destinations. A seventh load stalls until one of them broadcasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_valid | input | 1 | Queue head holds an instruction |
| iq_ready | output | 1 | A station of the presented class is free |
| iq_cls | input | 2 | Unit class: 0 adder, 1 multiplier, 2 load, 3 store |
| iq_dst | input | 3 | Destination register |
| iq_dst_en | input | 1 | Instruction writes `iq_dst` |
| iq_src1 | input | 3 | First source register |
| iq_src2 | input | 3 | Second source register |
| al_valid | output | 1 | Allocation this cycle |
| al_tag | output | 4 | Tag of the allocated station |
| al_cls | output | 2 | Class of the allocated station |
| al_v1 | output | 16 | First source value (valid when `al_q1` is 0) |
| al_q1 | output | 4 | First source producer tag, 0 when ready |
| al_v2 | output | 16 | Second source value (valid when `al_q2` is 0) |
| al_q2 | output | 4 | Second source producer tag, 0 when ready |
| bc_valid | input | 1 | Result broadcast this cycle |
| bc_tag | input | 4 | Tag of the broadcasting station |
| bc_data | input | 16 | Broadcast result |

## Verification
A corrupted status entry shows up on the next issue that reads that register, as a wrong tag or a stale value on `al_q`/`al_v` in the same cycle. A lost or extra busy bit shows up as a wrong `al_tag` or a wrong `iq_ready` the next time that class is requested. The register file can only be seen through issue, so every check of a committed value or of a stale-broadcast suppression is made by issuing a store that reads the register in the cycle after the broadcast edge. A long pseudo-random run then compares every allocation cycle against an independent model of status, values and busy bits.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_MUL   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } unit_cls_e;
endpackage

// File: rtl/rn_station_pool.sv
module rn_station_pool #(
  parameter int N_ADD = 3,
  parameter int N_MUL = 2,
  parameter int N_LD  = 6,
  parameter int N_ST  = 3,
  localparam int NST  = N_ADD + N_MUL + N_LD + N_ST,
  localparam int TW   = $clog2(NST + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     req_cls,
  input  logic           alloc_en,
  input  logic           free_en,
  input  logic [TW-1:0]  free_tag,
  output logic           has_free,
  output logic [TW-1:0]  alloc_tag,
  output logic [NST-1:0] busy
);
  import rn_pkg::*;

  localparam int BASE_MUL = N_ADD;
  localparam int BASE_LD  = N_ADD + N_MUL;
  localparam int BASE_ST  = N_ADD + N_MUL + N_LD;

  logic [NST-1:0] cand;

  for (genvar i = 0; i < NST; i++) begin : g_slot
    localparam unit_cls_e SLOT_CLS = (i < BASE_MUL) ? CLS_ADD :
                                     (i < BASE_LD)  ? CLS_MUL :
                                     (i < BASE_ST)  ? CLS_LOAD : CLS_STORE;
    localparam logic [TW-1:0] SLOT_TAG = TW'(i + 1);

    assign cand[i] = !busy[i] && (req_cls == SLOT_CLS);

    // allocation of a slot takes priority over a release in the same edge
    always_ff @(posedge clk) begin
      if (!rst_n)
        busy[i] <= 1'b0;
      else if (alloc_en && alloc_tag == SLOT_TAG)
        busy[i] <= 1'b1;
      else if (free_en && free_tag == SLOT_TAG)
        busy[i] <= 1'b0;
    end
  end

  // lowest free slot of the class: scan downwards so the last hit wins
  always_comb begin
    has_free  = 1'b0;
    alloc_tag = '0;
    for (int i = NST - 1; i >= 0; i--) begin
      if (cand[i]) begin
        has_free  = 1'b1;
        alloc_tag = TW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/rn_status_table.sv
module rn_status_table #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  input  logic          ren_en,
  input  logic [RW-1:0] ren_reg,
  input  logic [TW-1:0] ren_tag,
  output logic [TW-1:0] stat [NREG],
  output logic [DW-1:0] val  [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    logic renamed;

    assign hit     = bc_valid && (stat[r] != '0) && (stat[r] == bc_tag);
    assign renamed = ren_en && (ren_reg == RW'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[r] <= '0;
        val[r]  <= '0;
      end else begin
        if (hit) begin
          val[r]  <= bc_data;
          stat[r] <= '0;
        end
        // a rename in the same cycle overrides the clear
        if (renamed)
          stat[r] <= ren_tag;
      end
    end
  end
endmodule

// File: rtl/rn_src_read.sv
module rn_src_read #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [RW-1:0] sel,
  input  logic [TW-1:0] stat [NREG],
  input  logic [DW-1:0] val  [NREG],
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic [DW-1:0] op_val,
  output logic [TW-1:0] op_tag
);
  logic [TW-1:0] cur_tag;
  assign cur_tag = stat[sel];

  always_comb begin
    if (cur_tag == '0) begin
      op_val = val[sel];
      op_tag = '0;
    end else if (bc_valid && bc_tag == cur_tag) begin
      op_val = bc_data;
      op_tag = '0;
    end else begin
      op_val = '0;
      op_tag = cur_tag;
    end
  end
endmodule

// File: rtl/rn_issue_stage.sv
module rn_issue_stage #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int N_ADD = 3,
  parameter int N_MUL = 2,
  parameter int N_LD  = 6,
  parameter int N_ST  = 3,
  localparam int NST  = N_ADD + N_MUL + N_LD + N_ST,
  localparam int TW   = $clog2(NST + 1),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iq_valid,
  output logic          iq_ready,
  input  logic [1:0]    iq_cls,
  input  logic [RW-1:0] iq_dst,
  input  logic          iq_dst_en,
  input  logic [RW-1:0] iq_src1,
  input  logic [RW-1:0] iq_src2,
  output logic          al_valid,
  output logic [TW-1:0] al_tag,
  output logic [1:0]    al_cls,
  output logic [DW-1:0] al_v1,
  output logic [TW-1:0] al_q1,
  output logic [DW-1:0] al_v2,
  output logic [TW-1:0] al_q2,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data
);
  logic           has_free;
  logic           fire;
  logic [TW-1:0]  new_tag;
  logic [NST-1:0] busy;
  logic [TW-1:0]  stat [NREG];
  logic [DW-1:0]  val  [NREG];
  logic [RW-1:0]  src_sel [2];
  logic [DW-1:0]  src_v   [2];
  logic [TW-1:0]  src_q   [2];

  assign iq_ready = has_free;
  assign fire     = iq_valid && has_free;

  rn_station_pool #(
    .N_ADD(N_ADD), .N_MUL(N_MUL), .N_LD(N_LD), .N_ST(N_ST)
  ) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_cls  (iq_cls),
    .alloc_en (fire),
    .free_en  (bc_valid),
    .free_tag (bc_tag),
    .has_free (has_free),
    .alloc_tag(new_tag),
    .busy     (busy)
  );

  rn_status_table #(.NREG(NREG), .DW(DW), .TW(TW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .bc_valid(bc_valid),
    .bc_tag  (bc_tag),
    .bc_data (bc_data),
    .ren_en  (fire && iq_dst_en),
    .ren_reg (iq_dst),
    .ren_tag (new_tag),
    .stat    (stat),
    .val     (val)
  );

  assign src_sel[0] = iq_src1;
  assign src_sel[1] = iq_src2;

  for (genvar s = 0; s < 2; s++) begin : g_src
    rn_src_read #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd (
      .sel     (src_sel[s]),
      .stat    (stat),
      .val     (val),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_data (bc_data),
      .op_val  (src_v[s]),
      .op_tag  (src_q[s])
    );
  end

  assign al_valid = fire;
  assign al_tag   = new_tag;
  assign al_cls   = iq_cls;
  assign al_v1    = src_v[0];
  assign al_q1    = src_q[0];
  assign al_v2    = src_v[1];
  assign al_q2    = src_q[1];
endmodule

// File: rtl/rn_issue_checker.sv
module rn_issue_checker #(
  parameter int NST = 14,
  parameter int TW  = 4,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iq_valid,
  input logic           iq_ready,
  input logic           al_valid,
  input logic [TW-1:0]  al_tag,
  input logic [DW-1:0]  al_v1,
  input logic [TW-1:0]  al_q1,
  input logic           bc_valid,
  input logic [TW-1:0]  bc_tag,
  input logic [NST-1:0] busy
);
  logic [TW-1:0] al_idx;
  logic [TW-1:0] bc_idx;
  assign al_idx = al_tag - TW'(1);
  assign bc_idx = bc_tag - TW'(1);

  p_stall_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid && !iq_ready |-> !al_valid);

  p_tag_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid |-> (al_tag != '0 && al_tag <= TW'(NST)));

  p_alloc_was_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid |-> !busy[al_idx]);

  p_alloc_now_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid |=> busy[$past(al_idx)]);

  p_pending_no_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid && al_q1 != '0 |-> al_v1 == '0);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid && bc_valid && al_q1 != '0 |-> al_q1 != bc_tag);

  p_free_after_bc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && bc_tag != '0 && bc_tag <= TW'(NST) && !(al_valid && al_tag == bc_tag)
    |=> !busy[$past(bc_idx)]);
endmodule

bind rn_issue_stage rn_issue_checker #(.NST(NST), .TW(TW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .iq_valid(iq_valid),
  .iq_ready(iq_ready),
  .al_valid(al_valid),
  .al_tag  (al_tag),
  .al_v1   (al_v1),
  .al_q1   (al_q1),
  .bc_valid(bc_valid),
  .bc_tag  (bc_tag),
  .busy    (busy)
);

// File: tb/rn_issue_stage_test.sv
module rn_issue_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int NST  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iq_valid = 1'b0, iq_dst_en = 1'b0, bc_valid = 1'b0;
  logic [1:0] iq_cls = '0;
  logic [2:0] iq_dst = '0, iq_src1 = '0, iq_src2 = '0;
  logic [3:0] bc_tag = '0;
  logic [15:0] bc_data = '0;
  logic iq_ready, al_valid;
  logic [3:0] al_tag, al_q1, al_q2;
  logic [1:0] al_cls;
  logic [15:0] al_v1, al_v2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rn_issue_stage uut (
    .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_ready(iq_ready),
    .iq_cls(iq_cls), .iq_dst(iq_dst), .iq_dst_en(iq_dst_en),
    .iq_src1(iq_src1), .iq_src2(iq_src2), .al_valid(al_valid),
    .al_tag(al_tag), .al_cls(al_cls), .al_v1(al_v1), .al_q1(al_q1),
    .al_v2(al_v2), .al_q2(al_q2), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0]  mstat [NREG];
  logic [15:0] mval  [NREG];
  logic        mbusy [NST];
  logic        cap_ready;
  logic [3:0]  cap_tag, cap_q1;
  logic [15:0] cap_v1;

  function automatic int cbase(input int c);
    return (c == 0) ? 0 : (c == 1) ? 3 : (c == 2) ? 5 : 11;
  endfunction
  function automatic int ccnt(input int c);
    return (c == 0) ? 3 : (c == 1) ? 2 : (c == 2) ? 6 : 3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic src_exp(input logic [2:0] r, input logic bv, input logic [3:0] bt,
                         input logic [15:0] bd, output logic [15:0] ev, output logic [3:0] eq,
                         output bit byp);
    byp = 0;
    if (mstat[r] == 0) begin ev = mval[r]; eq = 0; end
    else if (bv && bt == mstat[r]) begin ev = bd; eq = 0; byp = 1; end
    else begin ev = 0; eq = mstat[r]; end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [2:0] d, input logic de,
                      input logic [2:0] a, input logic [2:0] b, input logic bv,
                      input logic [3:0] bt, input logic [15:0] bd);
    logic [3:0] etag, eq;
    logic [15:0] ev;
    bit found, byp, fire;
    @(negedge clk);
    iq_valid = v; iq_cls = c; iq_dst = d; iq_dst_en = de; iq_src1 = a; iq_src2 = b;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    #1;
    found = 0; etag = 0;
    for (int i = cbase(c); i < cbase(c) + ccnt(c); i++)
      if (!mbusy[i] && !found) begin found = 1; etag = 4'(i + 1); end
    fire = v && found;
    cap_ready = iq_ready; cap_tag = al_tag; cap_q1 = al_q1; cap_v1 = al_v1;
    chk(al_valid == fire, "R3 al_valid", 32'(al_valid), 32'(fire));
    if (v) chk(iq_ready == found, "R3 iq_ready", 32'(iq_ready), 32'(found));
    if (fire) begin
      chk(al_tag == etag, "R2 tag", 32'(al_tag), 32'(etag));
      src_exp(a, bv, bt, bd, ev, eq, byp);
      chk(al_q1 == eq && al_v1 == ev, byp ? "R8 src1" : "R4 src1", {12'h0, al_q1, al_v1}, {12'h0, eq, ev});
      src_exp(b, bv, bt, bd, ev, eq, byp);
      chk(al_q2 == eq && al_v2 == ev, byp ? "R8 src2" : "R4 src2", {12'h0, al_q2, al_v2}, {12'h0, eq, ev});
    end
    for (int r = 0; r < NREG; r++)
      if (bv && mstat[r] != 0 && mstat[r] == bt) begin mval[r] = bd; mstat[r] = 0; end
    if (fire && de) mstat[d] = etag;
    if (bv && bt != 0 && bt <= NST) mbusy[bt - 1] = 0;
    if (fire) mbusy[etag - 1] = 1;
  endtask

  // read a register through a store issue, then release the store
  task automatic rd(input logic [2:0] r, output logic [15:0] v, output logic [3:0] q);
    logic [3:0] t;
    step(1, 2'd3, 0, 0, r, r, 0, 0, 0);
    v = cap_v1; q = cap_q1; t = cap_tag;
    step(0, 0, 0, 0, 0, 0, 1, t, 16'hdead);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v, lf;
    logic [3:0] q, ta, tb, tt, t2;
    logic [3:0] lt [6];
    for (int r = 0; r < NREG; r++) begin mstat[r] = 0; mval[r] = 0; end
    for (int i = 0; i < NST; i++) mbusy[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state seen through reads of every register
    for (int r = 0; r < NREG; r++) begin
      rd(3'(r), v, q);
      chk(v == 0 && q == 0, "R1 reset reg", {12'h0, q, v}, 0);
    end

    // fill registers via producer + matching broadcast (R6)
    for (int r = 0; r < NREG; r++) begin
      step(1, 2'd0, 3'(r), 1, 0, 0, 0, 0, 0);
      tt = cap_tag;
      step(0, 0, 0, 0, 0, 0, 1, tt, 16'(r * 37 + 5));
    end
    for (int r = 0; r < NREG; r++) begin
      rd(3'(r), v, q);
      chk(v == 16'(r * 37 + 5) && q == 0, "R6 commit", {12'h0, q, v}, 32'(r * 37 + 5));
    end

    // R10: six loads outstanding, seventh stalls
    for (int k = 0; k < 6; k++) begin
      step(1, 2'd2, 3'(k), 1, 0, 0, 0, 0, 0);
      lt[k] = cap_tag;
      chk(cap_tag == 4'(6 + k), "R10 load tag", 32'(cap_tag), 32'(6 + k));
    end
    step(1, 2'd2, 3'd7, 1, 0, 0, 0, 0, 0);
    chk(!cap_ready, "R10 seventh load stalls", 32'(cap_ready), 0);
    rd(3'd7, v, q);
    chk(q == 0, "R3 stalled load left status", 32'(q), 0);
    // R7: free tag 8, it becomes the next load tag
    step(0, 0, 0, 0, 0, 0, 1, lt[2], 16'h0222);
    step(1, 2'd2, 3'd7, 1, 0, 0, 0, 0, 0);
    chk(cap_tag == 4'd8, "R7 reuse freed tag", 32'(cap_tag), 8);
    t2 = cap_tag;
    for (int k = 0; k < 6; k++)
      if (k != 2) step(0, 0, 0, 0, 0, 0, 1, lt[k], 16'(16'h0100 + k));
    step(0, 0, 0, 0, 0, 0, 1, t2, 16'h0777);
    rd(3'd7, v, q);
    chk(v == 16'h0777 && q == 0, "R7 late load commit", {12'h0, q, v}, 32'h0777);

    // R5 + R6: stale older broadcast is not committed
    step(1, 2'd2, 3'd3, 1, 0, 0, 0, 0, 0); ta = cap_tag;
    step(1, 2'd0, 3'd3, 1, 3'd3, 0, 0, 0, 0); tb = cap_tag;
    chk(cap_q1 == ta, "R5 own source sees older tag", 32'(cap_q1), 32'(ta));
    rd(3'd3, v, q);
    chk(q == tb, "R5 rename to newest", 32'(q), 32'(tb));
    step(0, 0, 0, 0, 0, 0, 1, ta, 16'haaaa);
    rd(3'd3, v, q);
    chk(q == tb && v == 0, "R6 stale result dropped", {12'h0, q, v}, {12'h0, tb, 16'h0});
    step(0, 0, 0, 0, 0, 0, 1, tb, 16'hbbbb);
    rd(3'd3, v, q);
    chk(q == 0 && v == 16'hbbbb, "R6 latest result kept", {12'h0, q, v}, 32'hbbbb);

    // R8: same-cycle bypass
    step(1, 2'd1, 3'd5, 1, 0, 0, 0, 0, 0); tt = cap_tag;
    step(1, 2'd3, 0, 0, 3'd5, 3'd5, 1, tt, 16'h1234);
    chk(cap_q1 == 0 && cap_v1 == 16'h1234, "R8 bypass", {12'h0, cap_q1, cap_v1}, 32'h1234);
    step(0, 0, 0, 0, 0, 0, 1, cap_tag, 0);

    // R9: same-cycle rename beats broadcast clear
    step(1, 2'd0, 3'd6, 1, 0, 0, 0, 0, 0); tt = cap_tag;
    step(1, 2'd2, 3'd6, 1, 0, 0, 1, tt, 16'h5555); t2 = cap_tag;
    rd(3'd6, v, q);
    chk(q == t2, "R9 new tag kept", 32'(q), 32'(t2));
    step(0, 0, 0, 0, 0, 0, 1, t2, 16'h6666);
    rd(3'd6, v, q);
    chk(q == 0 && v == 16'h6666, "R9 final value", {12'h0, q, v}, 32'h6666);

    // pseudo-random sweep against the model
    lf = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] bt;
      logic bv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bv = 0; bt = 0;
      for (int j = 0; j < NST; j++) begin
        int s;
        s = (j + int'(lf[15:12])) % NST;
        if (!bv && mbusy[s] && lf[11]) begin bv = 1; bt = 4'(s + 1); end
      end
      step(lf[9] | lf[10], lf[1:0], lf[4:2], lf[1:0] != 2'd3, lf[7:5], lf[10:8],
           bv, bt, lf ^ 16'(n));
    end
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule